// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Start-Bit Qualification

This block receives 8-bit characters from an asynchronous serial line. A programmable divisor cuts the system clock down to a sampling tick running at sixteen times the baud rate. The receiver accepts a start bit only after the line has been low long enough. It then samples every later bit at the nominal centre of the bit cell. The raw line passes through a two-flop synchroniser before any logic uses it.

Three single-cycle command inputs control the receiver. One switches it on. One switches it off, either at once or at the end of the current character. One aborts whatever it is doing. A finished byte goes into a holding register and raises a ready flag. Overrun and framing errors are kept as sticky flags, and a separate input clears them. A read-acknowledge input clears the ready flag.

Top module: `uart_rx_qual`

## Requirements
- R1: After reset the receiver is off, and `rx_data`, `rx_ready`, `overrun_err` and `frame_err` are all 0. While it is off, line activity produces no character. A `cmd_enable` pulse makes it start hunting for a start bit.
- R2: A `cmd_disable` pulse while the receiver is hunting turns it off at once. A `cmd_disable` pulse during a character lets that character finish through its stop sample and deliver its byte; the receiver then turns off.
- R3: A `cmd_reset` pulse aborts any character in progress at once and leaves the receiver off. The partial byte is never delivered, and the ready and error flags keep their values.
- R4: The sampling tick occurs once every `divisor` system clocks, and one bit cell lasts 16 ticks. A divisor of 0 stops the tick, so no character is received.
- R5: A low line starts a character only if it is seen on more than 7 consecutive ticks. A low lasting 7 ticks or fewer is ignored. A high tick before qualification restarts the low count from zero.
- R6: The first data bit is sampled 24 ticks after the first low tick of the start bit. Each later bit, including the stop bit, is sampled 16 ticks after the previous sample.
- R7: A frame is a low start bit, then 8 data bits with bit 0 first, then one stop bit. A stop sample of 0 sets `frame_err`.
- R8: A completed character loads `rx_data` and sets `rx_ready`. If `rx_ready` is still set and is not acknowledged in the completion cycle, `overrun_err` is set and the new byte replaces the old one.
- R9: `rd_ack` clears `rx_ready` and `clr_status` clears `overrun_err` and `frame_err`. If a completion falls in the same cycle as `rd_ack`, `rx_ready` stays set and no overrun is flagged.
- R10: If several commands arrive in the same cycle, `cmd_reset` takes precedence over `cmd_disable`, and `cmd_disable` takes precedence over `cmd_enable`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| divisor | input | 16 | Clocks per sampling tick; 0 stops the tick |
| cmd_enable | input | 1 | Pulse: start hunting for characters |
| cmd_disable | input | 1 | Pulse: stop now if idle, or after the current character |
| cmd_reset | input | 1 | Pulse: abort at once and turn off |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rd_ack | input | 1 | Pulse: clears the ready flag |
| clr_status | input | 1 | Pulse: clears the overrun and framing flags |
| rx_data | output | 8 | Last received byte |
| rx_ready | output | 1 | A byte is waiting to be read |
| overrun_err | output | 1 | Sticky: a byte was overwritten before being read |
| frame_err | output | 1 | Sticky: a stop bit was sampled low |

## Verification
Character completion and `rd_ack` can land in the same clock. The bench provokes this by leaving one byte unread, then sending a second character at a divisor of 1. It pulses `rd_ack` in exactly the cycle of the stop sample, 152 ticks after the synchronised falling edge. The result is judged correct only if `rx_ready` stays set, `overrun_err` stays clear and `rx_data` holds the new byte. An acknowledge one cycle late would leave the flag cleared, and an overrun path that ignores the acknowledge would raise the error.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HUNT = 2'd1,
        ST_RECV = 2'd2
    } srx_state_e;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{IDLE}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/srx_tick.sv
module srx_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (divisor == '0)      cnt_d = '0;
        else if (cnt_q <= ONE)  cnt_d = divisor;
        else                    cnt_d = cnt_q - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == ONE);
endmodule

// File: rtl/srx_engine.sv
module srx_engine
    import srx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int OVS      = 16,
    parameter int QUAL_MIN = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_s,
    input  logic              cmd_en,
    input  logic              cmd_dis,
    input  logic              cmd_rst,
    output logic              done_o,
    output logic              stop_ok_o,
    output logic [DATA_W-1:0] byte_o,
    output srx_state_e        state_o
);
    localparam int FIRST_SAMPLE = OVS + OVS / 2;
    localparam int REARM        = OVS / 2 + 1;
    localparam int CNT_W        = $clog2(FIRST_SAMPLE + 1);
    localparam int BIT_W        = $clog2(DATA_W + 1);

    typedef struct packed {
        srx_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  bidx;
        logic [DATA_W-1:0] shreg;
        logic              stop_pend;
    } eng_t;

    eng_t q, d;
    logic done, stop_ok;

    always_comb begin
        d       = q;
        done    = 1'b0;
        stop_ok = 1'b0;

        case (q.state)
            ST_HUNT: begin
                if (tick) begin
                    if (rx_s) begin
                        d.cnt = '0;
                    end else if (q.cnt == CNT_W'(QUAL_MIN)) begin
                        d.state = ST_RECV;
                        d.cnt   = CNT_W'(QUAL_MIN + 1);
                        d.bidx  = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_RECV: begin
                if (tick) begin
                    if (q.cnt == CNT_W'(FIRST_SAMPLE)) begin
                        d.cnt = CNT_W'(REARM);
                        if (q.bidx == BIT_W'(DATA_W)) begin
                            done        = 1'b1;
                            stop_ok     = rx_s;
                            d.cnt       = '0;
                            d.bidx      = '0;
                            d.stop_pend = 1'b0;
                            d.state     = q.stop_pend ? ST_OFF : ST_HUNT;
                        end else begin
                            d.shreg = {rx_s, q.shreg[DATA_W-1:1]};
                            d.bidx  = q.bidx + 1'b1;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                d.cnt  = '0;
                d.bidx = '0;
            end
        endcase

        // Command arbitration: reset over disable over enable.
        if (cmd_rst) begin
            d.state     = ST_OFF;
            d.cnt       = '0;
            d.bidx      = '0;
            d.shreg     = '0;
            d.stop_pend = 1'b0;
            done        = 1'b0;
        end else if (cmd_dis) begin
            if (d.state == ST_RECV) begin
                d.stop_pend = 1'b1;
            end else begin
                d.state     = ST_OFF;
                d.cnt       = '0;
                d.stop_pend = 1'b0;
            end
        end else if (cmd_en) begin
            d.stop_pend = 1'b0;
            if (d.state == ST_OFF) begin
                d.state = ST_HUNT;
                d.cnt   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state     <= ST_OFF;
            q.cnt       <= '0;
            q.bidx      <= '0;
            q.shreg     <= '0;
            q.stop_pend <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign done_o    = done;
    assign stop_ok_o = stop_ok;
    assign byte_o    = q.shreg;
    assign state_o   = q.state;
endmodule

// File: rtl/srx_hold.sv
module srx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic              stop_ok,
    input  logic [DATA_W-1:0] new_byte,
    input  logic              rd_ack,
    input  logic              clr_status,
    output logic [DATA_W-1:0] data_o,
    output logic              ready_o,
    output logic              overrun_o,
    output logic              frame_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ready;
        logic              overrun;
        logic              frame;
    } hold_t;

    hold_t q, d;

    always_comb begin
        d = q;
        if (rd_ack)     d.ready   = 1'b0;
        if (clr_status) begin
            d.overrun = 1'b0;
            d.frame   = 1'b0;
        end
        if (done) begin
            d.data  = new_byte;
            d.ready = 1'b1;
            if (q.ready && !rd_ack) d.overrun = 1'b1;
            if (!stop_ok)           d.frame   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign data_o    = q.data;
    assign ready_o   = q.ready;
    assign overrun_o = q.overrun;
    assign frame_o   = q.frame;
endmodule

// File: rtl/uart_rx_qual.sv
module uart_rx_qual #(
    parameter int DATA_W   = 8,
    parameter int DIV_W    = 16,
    parameter int OVS      = 16,
    parameter int QUAL_MIN = 7,
    parameter int SYNC_N   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              cmd_enable,
    input  logic              cmd_disable,
    input  logic              cmd_reset,
    input  logic              rx_line,
    input  logic              rd_ack,
    input  logic              clr_status,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              overrun_err,
    output logic              frame_err
);
    logic               rx_s;
    logic               samp_tick;
    logic               eng_done;
    logic               eng_stop_ok;
    logic [DATA_W-1:0]  eng_byte;
    srx_pkg::srx_state_e eng_state;

    srx_sync #(.STAGES(SYNC_N), .IDLE(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (rx_s)
    );

    srx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .divisor(divisor),
        .tick   (samp_tick)
    );

    srx_engine #(.DATA_W(DATA_W), .OVS(OVS), .QUAL_MIN(QUAL_MIN)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (samp_tick),
        .rx_s     (rx_s),
        .cmd_en   (cmd_enable),
        .cmd_dis  (cmd_disable),
        .cmd_rst  (cmd_reset),
        .done_o   (eng_done),
        .stop_ok_o(eng_stop_ok),
        .byte_o   (eng_byte),
        .state_o  (eng_state)
    );

    srx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (eng_done),
        .stop_ok   (eng_stop_ok),
        .new_byte  (eng_byte),
        .rd_ack    (rd_ack),
        .clr_status(clr_status),
        .data_o    (rx_data),
        .ready_o   (rx_ready),
        .overrun_o (overrun_err),
        .frame_o   (frame_err)
    );
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int DIV_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [DIV_W-1:0]    divisor,
    input logic                cmd_enable,
    input logic                cmd_disable,
    input logic                cmd_reset,
    input logic                rd_ack,
    input logic                rx_ready,
    input logic                overrun_err,
    input logic                samp_tick,
    input logic                eng_done,
    input srx_pkg::srx_state_e eng_state
);
    import srx_pkg::*;

    p_abort_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> (eng_state == ST_OFF));

    p_idle_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_disable && !cmd_reset && eng_state == ST_HUNT) |=> (eng_state == ST_OFF));

    p_busy_finish_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_disable && !cmd_reset && !eng_done && eng_state == ST_RECV) |=> (eng_state == ST_RECV));

    p_dis_beats_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_enable && cmd_disable && eng_state == ST_OFF) |=> (eng_state == ST_OFF));

    p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_tick && divisor > DIV_W'(1) && $stable(divisor)) |=> !samp_tick);

    p_zero_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor == '0 && $past(divisor) == '0) |-> !samp_tick);

    p_ready_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> rx_ready);

    p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && rx_ready && !rd_ack) |=> overrun_err);

    p_ack_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !eng_done) |=> !rx_ready);
endmodule

bind uart_rx_qual srx_checker #(.DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .divisor    (divisor),
    .cmd_enable (cmd_enable),
    .cmd_disable(cmd_disable),
    .cmd_reset  (cmd_reset),
    .rd_ack     (rd_ack),
    .rx_ready   (rx_ready),
    .overrun_err(overrun_err),
    .samp_tick  (samp_tick),
    .eng_done   (eng_done),
    .eng_state  (eng_state)
);

// File: tb/sim_uart_rx_qual.sv
module sim_uart_rx_qual;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] divisor = 16'd4;
    logic        cmd_enable = 1'b0, cmd_disable = 1'b0, cmd_reset = 1'b0;
    logic        rx_line = 1'b1, rd_ack = 1'b0, clr_status = 1'b0;
    logic [7:0]  rx_data;
    logic        rx_ready, overrun_err, frame_err;
    int          total = 0;
    int          bad = 0;

    always #4 clk = ~clk;

    uart_rx_qual u0 (
        .clk(clk), .rst_n(rst_n), .divisor(divisor),
        .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .cmd_reset(cmd_reset),
        .rx_line(rx_line), .rd_ack(rd_ack), .clr_status(clr_status),
        .rx_data(rx_data), .rx_ready(rx_ready),
        .overrun_err(overrun_err), .frame_err(frame_err)
    );

    // {stop bit, data byte}
    localparam logic [8:0] VEC [0:5] = '{9'h155, 9'h1A3, 9'h100, 9'h1FF, 9'h03C, 9'h181};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] dat, input logic stop, input int bt);
        @(negedge clk); rx_line = 1'b0;
        repeat (bt) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            rx_line = dat[k];
            repeat (bt) @(negedge clk);
        end
        if (stop) begin
            rx_line = 1'b1;
            repeat (bt) @(negedge clk);
        end else begin
            rx_line = 1'b0;
            repeat (bt * 5 / 8) @(negedge clk);
            rx_line = 1'b1;
        end
        rx_line = 1'b1;
    endtask

    // Divisor 1: each bit holds its value only near offset 8 of its cell.
    task automatic send_narrow(input logic [7:0] dat);
        @(negedge clk); rx_line = 1'b0;
        repeat (16) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            for (int c = 0; c < 16; c++) begin
                rx_line = (c >= 6 && c <= 10) ? dat[k] : ~dat[k];
                @(negedge clk);
            end
        end
        rx_line = 1'b1;
        repeat (16) @(negedge clk);
    endtask

    task automatic low_glitch(input int n);
        @(negedge clk); rx_line = 1'b0;
        repeat (n) @(negedge clk);
        rx_line = 1'b1;
    endtask

    task automatic clear_all();
        @(negedge clk); rd_ack = 1'b1; clr_status = 1'b1;
        @(negedge clk); rd_ack = 1'b0; clr_status = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 data after reset", rx_data, 8'h00);
        chk("R1 ready after reset", rx_ready, 0);
        chk("R1 overrun after reset", overrun_err, 0);
        chk("R1 frame after reset", frame_err, 0);

        // R1 disabled receiver ignores a frame
        send_frame(8'h5A, 1'b1, 64);
        repeat (40) @(negedge clk);
        chk("R1 no byte while off", rx_ready, 0);

        pulse(cmd_enable);
        repeat (10) @(negedge clk);

        // R7 table of frames at divisor 4
        for (int i = 0; i < 6; i++) begin
            send_frame(VEC[i][7:0], VEC[i][8], 64);
            repeat (30) @(negedge clk);
            chk("R7 vector data", rx_data, VEC[i][7:0]);
            chk("R8 vector ready", rx_ready, 1);
            chk("R7 vector frame flag", frame_err, !VEC[i][8]);
            clear_all();
            repeat (80) @(negedge clk);
        end

        // R8 overrun at divisor 1
        divisor = 16'd1;
        repeat (20) @(negedge clk);
        send_frame(8'h12, 1'b1, 16);
        repeat (10) @(negedge clk);
        send_frame(8'h34, 1'b1, 16);
        repeat (10) @(negedge clk);
        chk("R8 overrun set", overrun_err, 1);
        chk("R8 newer byte kept", rx_data, 8'h34);
        pulse(clr_status);
        chk("R9 status clear", overrun_err, 0);
        chk("R9 status clear keeps ready", rx_ready, 1);

        // R9 acknowledge in the completion cycle
        fork
            send_frame(8'hC7, 1'b1, 16);
            begin
                @(negedge clk);
                repeat (154) @(negedge clk);
                rd_ack = 1'b1;
                @(negedge clk);
                rd_ack = 1'b0;
            end
        join
        repeat (10) @(negedge clk);
        chk("R9 same-cycle ack ready", rx_ready, 1);
        chk("R9 same-cycle ack no overrun", overrun_err, 0);
        chk("R9 same-cycle ack data", rx_data, 8'hC7);
        pulse(rd_ack);
        chk("R9 ack clears ready", rx_ready, 0);

        // R6 centre sampling
        send_narrow(8'hB4);
        repeat (10) @(negedge clk);
        chk("R6 centre sample data", rx_data, 8'hB4);
        chk("R6 centre sample frame", frame_err, 0);
        clear_all();
        repeat (20) @(negedge clk);

        // R5 start qualification
        low_glitch(7);
        repeat (300) @(negedge clk);
        chk("R5 seven-tick low ignored", rx_ready, 0);
        low_glitch(5);
        low_glitch(5);
        repeat (300) @(negedge clk);
        chk("R5 count restarts on high", rx_ready, 0);
        low_glitch(8);
        repeat (300) @(negedge clk);
        chk("R5 eight-tick low accepted", rx_ready, 1);
        chk("R5 eight-tick low data", rx_data, 8'hFF);
        clear_all();
        repeat (20) @(negedge clk);

        // R2 disable while hunting
        pulse(cmd_disable);
        send_frame(8'h66, 1'b1, 16);
        repeat (20) @(negedge clk);
        chk("R2 idle disable immediate", rx_ready, 0);
        pulse(cmd_enable);
        repeat (10) @(negedge clk);

        // R2 disable mid-character
        fork
            send_frame(8'h5A, 1'b1, 16);
            begin repeat (60) @(negedge clk); pulse(cmd_disable); end
        join
        repeat (10) @(negedge clk);
        chk("R2 busy disable finishes", rx_ready, 1);
        chk("R2 busy disable data", rx_data, 8'h5A);
        clear_all();
        send_frame(8'h11, 1'b1, 16);
        repeat (20) @(negedge clk);
        chk("R2 off after finishing", rx_ready, 0);

        // R10 priorities
        @(negedge clk); cmd_enable = 1'b1; cmd_disable = 1'b1;
        @(negedge clk); cmd_enable = 1'b0; cmd_disable = 1'b0;
        send_frame(8'h22, 1'b1, 16);
        repeat (20) @(negedge clk);
        chk("R10 disable beats enable", rx_ready, 0);
        @(negedge clk); cmd_enable = 1'b1; cmd_reset = 1'b1;
        @(negedge clk); cmd_enable = 1'b0; cmd_reset = 1'b0;
        send_frame(8'h23, 1'b1, 16);
        repeat (20) @(negedge clk);
        chk("R10 reset beats enable", rx_ready, 0);
        pulse(cmd_enable);
        repeat (10) @(negedge clk);

        // R3 abort mid-character
        fork
            send_frame(8'h99, 1'b0, 16);
            begin repeat (60) @(negedge clk); pulse(cmd_reset); end
        join
        repeat (20) @(negedge clk);
        chk("R3 aborted byte dropped", rx_ready, 0);
        chk("R3 no frame flag from abort", frame_err, 0);
        send_frame(8'h44, 1'b1, 16);
        repeat (20) @(negedge clk);
        chk("R3 off after abort", rx_ready, 0);
        pulse(cmd_enable);
        repeat (10) @(negedge clk);
        send_frame(8'h45, 1'b1, 16);
        repeat (10) @(negedge clk);
        chk("R3 recovers after enable", rx_data, 8'h45);
        clear_all();

        // R4 divisor rate and zero divisor
        divisor = 16'd3;
        repeat (20) @(negedge clk);
        send_frame(8'h96, 1'b1, 48);
        repeat (30) @(negedge clk);
        chk("R4 divisor 3 data", rx_data, 8'h96);
        chk("R4 divisor 3 ready", rx_ready, 1);
        clear_all();
        divisor = 16'd0;
        repeat (10) @(negedge clk);
        send_frame(8'h0F, 1'b1, 16);
        repeat (50) @(negedge clk);
        chk("R4 zero divisor no byte", rx_ready, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule